// File: doc/BRIEF.md
# BCD real-time clock with alarm

This block keeps a calendar clock as packed BCD bytes: seconds, minutes, hours (24-hour only), day of month, month and a two-digit year. A tick enable input, nominally 32.768 kHz, feeds a sub-second divider. When the divider completes a second, the calendar advances. The carry ripples through the fields, and the day field wraps at the real length of the month, including leap-year February.

Software reaches every register through a byte-wide bus: address, write strobe, write data and combinational read data. A six-field alarm is compared with the current time at all times. A match sets a sticky alarm flag. A once-per-second event flag drives a periodic interrupt. A BUSY status bit is high during the final tick period before each second update, so software can wait for it to drop and then access the time fields safely.

Top module: `bcd_rtc_top`

## Requirements
- R1: After reset the time fields hold seconds 00, minutes 00, hours 00, day 01, month 01 and year 00, which gives the address map below. Control reads 0x00, status reads 0x80 and interrupt enable reads 0x00, and both interrupt outputs are low.
  - The time fields are at byte addresses 0x00 (seconds), 0x04 (minutes), 0x08 (hours), 0x0C (day), 0x10 (month) and 0x14 (year).
  - The alarm fields use the same order at 0x20 through 0x34.
  - Control is at 0x40, status at 0x44 and interrupt enable at 0x48.
- R2: On each second update the BCD fields advance with decimal carry. Seconds and minutes wrap from 59 to 00, and hours wrap from 23 to 00.
- R3: The day wraps to 01 after 30 in April, June, September and November, after 31 in the other months, and after 29 in February of a year divisible by 4 (after 28 otherwise). The month wraps from 12 to 01, and the year wraps from 99 to 00.
- R4: Control bit 0 set makes the clock run. With it clear the time does not advance. Status bit 1 reads the running state.
- R5: A write to any time field loads that field and restarts the divider. The next second update follows exactly TICKS_PER_SEC ticks after the last such write.
- R6: Status bit 0 (BUSY) is high exactly during the last tick period before a second update, and only while running.
- R7: The alarm flag, status bit 6, is set when all six time fields equal the six alarm fields. It stays clear if any single field differs.
- R8: Writing 1 to status bit 6 clears the alarm flag, and writing 1 to status bit 7 clears the power-up flag. Writing 0 to these bits has no effect. If a clear and a new alarm match fall in the same cycle, the flag stays set.
- R9: After a second update, status bit 2 (second), bit 3 (minute rollover), bit 4 (hour rollover) and bit 5 (day rollover) are high for one tick period.
- R10: The periodic interrupt output equals status bit 2 AND interrupt-enable bit 2. The alarm interrupt output equals the alarm flag AND interrupt-enable bit 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Sub-second tick enable (one clock wide) |
| addr_i | input | ADDR_W | Register byte address |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for addr_i |
| irq_tick_o | output | 1 | Periodic one-second interrupt |
| irq_alarm_o | output | 1 | Alarm interrupt |

## Verification
The two functions that can coincide are the alarm flag being set by a fresh time match and software clearing that flag with a write-1 to status bit 6. The bench loads a time one second before the alarm and counts the divider's ticks from the last load. It then places the clearing write in the exact cycle in which the new match is first seen. Afterwards it reads the status register and expects the flag to remain set. A second clear, made once the match is old, must then remove it.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int unsigned NF    = 6;
   localparam int unsigned F_SEC = 0;
   localparam int unsigned F_MIN = 1;
   localparam int unsigned F_HR  = 2;
   localparam int unsigned F_DAY = 3;
   localparam int unsigned F_MON = 4;
   localparam int unsigned F_YR  = 5;

   localparam logic [7:0] A_TIME  = 8'h00;
   localparam logic [7:0] A_ALARM = 8'h20;
   localparam logic [7:0] A_CTRL  = 8'h40;
   localparam logic [7:0] A_STAT  = 8'h44;
   localparam logic [7:0] A_IE    = 8'h48;

   typedef logic [NF-1:0][7:0] rtc_fields_t;

   localparam rtc_fields_t RESET_TIME = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
      else                return {v[7:4], v[3:0] + 4'h1};
   endfunction

   function automatic logic leap_year(input logic [7:0] y);
      if (y[4]) return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
      else      return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
   endfunction

   function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
      case (mon)
         8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction
endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
   parameter int unsigned TICKS = 32768
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic run_i,
   input  logic restart_i,
   output logic step_o,
   output logic busy_o
);
   localparam int unsigned CW = $clog2(TICKS);
   localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

   if (TICKS < 2) begin : g_bad_ticks
      $error("rtc_divider: TICKS must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   assign busy_o = run_i && (cnt_q == LAST);
   assign step_o = busy_o && tick_i && !restart_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '0;
      else if (restart_i)       cnt_q <= '0;
      else if (run_i && tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
   import rtc_pkg::*;
(
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          step_i,
   input  logic [NF-1:0] wr_i,
   input  logic [7:0]    wdata_i,
   output rtc_fields_t   time_o,
   output logic          roll_min_o,
   output logic          roll_hr_o,
   output logic          roll_day_o
);
   rtc_fields_t tm_q, tm_d;
   logic wrap_s, wrap_m, wrap_h, wrap_d, wrap_mo;

   always_comb begin
      wrap_s  = tm_q[F_SEC] == 8'h59;
      wrap_m  = tm_q[F_MIN] == 8'h59;
      wrap_h  = tm_q[F_HR]  == 8'h23;
      wrap_d  = tm_q[F_DAY] == month_len(tm_q[F_MON], tm_q[F_YR]);
      wrap_mo = tm_q[F_MON] == 8'h12;
      tm_d = tm_q;
      if (step_i) begin
         tm_d[F_SEC] = wrap_s ? 8'h00 : bcd_inc(tm_q[F_SEC]);
         if (wrap_s) begin
            tm_d[F_MIN] = wrap_m ? 8'h00 : bcd_inc(tm_q[F_MIN]);
            if (wrap_m) begin
               tm_d[F_HR] = wrap_h ? 8'h00 : bcd_inc(tm_q[F_HR]);
               if (wrap_h) begin
                  tm_d[F_DAY] = wrap_d ? 8'h01 : bcd_inc(tm_q[F_DAY]);
                  if (wrap_d) begin
                     tm_d[F_MON] = wrap_mo ? 8'h01 : bcd_inc(tm_q[F_MON]);
                     if (wrap_mo)
                        tm_d[F_YR] = (tm_q[F_YR] == 8'h99) ? 8'h00 : bcd_inc(tm_q[F_YR]);
                  end
               end
            end
         end
      end
      for (int i = 0; i < NF; i++)
         if (wr_i[i]) tm_d[i] = wdata_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tm_q <= RESET_TIME;
      else         tm_q <= tm_d;
   end

   assign time_o     = tm_q;
   assign roll_min_o = step_i && wrap_s;
   assign roll_hr_o  = roll_min_o && wrap_m;
   assign roll_day_o = roll_hr_o && wrap_h;
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
   import rtc_pkg::*;
(
   input  rtc_fields_t now_i,
   input  rtc_fields_t alarm_i,
   output logic        match_o
);
   logic [NF-1:0] eq;

   for (genvar g = 0; g < NF; g++) begin : g_fld
      assign eq[g] = (now_i[g] == alarm_i[g]);
   end

   assign match_o = &eq;
endmodule

// File: rtl/bcd_rtc_top.sv
module bcd_rtc_top
   import rtc_pkg::*;
#(
   parameter int unsigned TICKS_PER_SEC = 32768,
   parameter int unsigned ADDR_W        = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic [7:0]        wdata_i,
   output logic [7:0]        rdata_o,
   output logic              irq_tick_o,
   output logic              irq_alarm_o
);
   if (ADDR_W < 7) begin : g_bad_addr
      $error("bcd_rtc_top: ADDR_W must reach the interrupt enable register");
   end

   logic [NF-1:0] tm_wr, al_wr;
   rtc_fields_t   tm_q, alarm_q;
   logic          time_wr, stat_wr, ctrl_wr, ie_wr;
   logic          run_q, ie_tick_q, ie_alarm_q, alarm_f_q, pwr_f_q, match_q;
   logic          sec_step, busy, match, roll_min, roll_hr, roll_day;
   logic [3:0]    evt_q;

   for (genvar g = 0; g < NF; g++) begin : g_fld
      assign tm_wr[g] = wr_i && (addr_i == ADDR_W'(A_TIME + 4 * g));
      assign al_wr[g] = wr_i && (addr_i == ADDR_W'(A_ALARM + 4 * g));
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)      alarm_q[g] <= 8'h00;
         else if (al_wr[g]) alarm_q[g] <= wdata_i;
      end
   end

   assign time_wr = |tm_wr;
   assign ctrl_wr = wr_i && (addr_i == ADDR_W'(A_CTRL));
   assign stat_wr = wr_i && (addr_i == ADDR_W'(A_STAT));
   assign ie_wr   = wr_i && (addr_i == ADDR_W'(A_IE));

   rtc_divider #(.TICKS(TICKS_PER_SEC)) i_div (
      .clk_i, .rst_ni, .tick_i, .run_i(run_q), .restart_i(time_wr),
      .step_o(sec_step), .busy_o(busy)
   );

   rtc_calendar i_cal (
      .clk_i, .rst_ni, .step_i(sec_step), .wr_i(tm_wr), .wdata_i,
      .time_o(tm_q), .roll_min_o(roll_min), .roll_hr_o(roll_hr), .roll_day_o(roll_day)
   );

   rtc_alarm_match i_match (.now_i(tm_q), .alarm_i(alarm_q), .match_o(match));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q      <= 1'b0;
         ie_tick_q  <= 1'b0;
         ie_alarm_q <= 1'b0;
         alarm_f_q  <= 1'b0;
         pwr_f_q    <= 1'b1;
         match_q    <= 1'b0;
         evt_q      <= '0;
      end else begin
         match_q <= match;
         if (ctrl_wr) run_q <= wdata_i[0];
         if (ie_wr) begin
            ie_tick_q  <= wdata_i[2];
            ie_alarm_q <= wdata_i[3];
         end
         if (match && !match_q)           alarm_f_q <= 1'b1;
         else if (stat_wr && wdata_i[6])  alarm_f_q <= 1'b0;
         if (stat_wr && wdata_i[7])       pwr_f_q   <= 1'b0;
         if (sec_step)    evt_q <= {roll_day, roll_hr, roll_min, 1'b1};
         else if (tick_i) evt_q <= '0;
      end
   end

   always_comb begin
      rdata_o = 8'h00;
      for (int i = 0; i < NF; i++) begin
         if (addr_i == ADDR_W'(A_TIME + 4 * i))  rdata_o = tm_q[i];
         if (addr_i == ADDR_W'(A_ALARM + 4 * i)) rdata_o = alarm_q[i];
      end
      if (addr_i == ADDR_W'(A_CTRL)) rdata_o = {7'b0, run_q};
      if (addr_i == ADDR_W'(A_STAT)) rdata_o = {pwr_f_q, alarm_f_q, evt_q, run_q, busy};
      if (addr_i == ADDR_W'(A_IE))   rdata_o = {4'b0, ie_alarm_q, ie_tick_q, 2'b0};
   end

   assign irq_tick_o  = evt_q[0] && ie_tick_q;
   assign irq_alarm_o = alarm_f_q && ie_alarm_q;
endmodule

// File: rtl/bcd_rtc_chk.sv
module bcd_rtc_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       tick_i,
   input logic       busy_i,
   input logic       run_i,
   input logic       time_wr_i,
   input logic       step_i,
   input logic [7:0] sec_i,
   input logic       match_i,
   input logic       alarm_f_i,
   input logic       clr_alarm_i,
   input logic       evt_sec_i
);
   AST_STOP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_i && !time_wr_i) |=> $stable(sec_i)) else $error("stopped clock moved"); // R4

   AST_BUSY_THEN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_i && tick_i && !time_wr_i) |=> !$stable(sec_i)) else $error("busy tick without update"); // R6

   AST_ALARM_ON_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(alarm_f_i) |-> $past(match_i)) else $error("alarm flag without match"); // R7

   AST_ALARM_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (alarm_f_i && !clr_alarm_i) |=> alarm_f_i) else $error("alarm flag dropped"); // R8

   AST_EVT_AFTER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(evt_sec_i) |-> $past(step_i)) else $error("second event without update"); // R9
endmodule

bind bcd_rtc_top bcd_rtc_chk i_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .busy_i(busy), .run_i(run_q),
   .time_wr_i(time_wr), .step_i(sec_step), .sec_i(tm_q[0]), .match_i(match),
   .alarm_f_i(alarm_f_q), .clr_alarm_i(stat_wr && wdata_i[6]), .evt_sec_i(evt_q[0])
);

// File: tb/test_bcd_rtc_top.sv
`timescale 1ns/100ps
module test_bcd_rtc_top;
   localparam int unsigned TPS = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b1;
   logic [7:0] addr = 8'h00;
   logic       wr = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       irq_tick, irq_alarm;
   int         tests = 0;
   int         fails = 0;

   always #2.5 clk = ~clk;

   bcd_rtc_top #(.TICKS_PER_SEC(TPS), .ADDR_W(8)) i_bcd_rtc_top (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr), .wr_i(wr),
      .wdata_i(wdata), .rdata_o(rdata), .irq_tick_o(irq_tick), .irq_alarm_o(irq_alarm)
   );

   typedef struct packed {
      logic [47:0] st;
      logic [47:0] ex;
      logic [7:0]  ev;
   } vec_t;

   // fields packed year, month, day, hour, minute, second
   localparam vec_t VEC [10] = '{
      '{48'h99_12_31_23_59_59, 48'h00_01_01_00_00_00, 8'h3C},
      '{48'h24_02_28_23_59_59, 48'h24_02_29_00_00_00, 8'h3C},
      '{48'h24_02_29_23_59_59, 48'h24_03_01_00_00_00, 8'h3C},
      '{48'h23_02_28_23_59_59, 48'h23_03_01_00_00_00, 8'h3C},
      '{48'h25_04_30_23_59_59, 48'h25_05_01_00_00_00, 8'h3C},
      '{48'h25_01_31_12_34_09, 48'h25_01_31_12_34_10, 8'h04},
      '{48'h25_06_15_10_59_59, 48'h25_06_15_11_00_00, 8'h1C},
      '{48'h00_02_28_23_59_59, 48'h00_02_29_00_00_00, 8'h3C},
      '{48'h10_02_28_23_59_59, 48'h10_03_01_00_00_00, 8'h3C},
      '{48'h12_02_28_23_59_59, 48'h12_02_29_00_00_00, 8'h3C}
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wreg(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rreg(input logic [7:0] a, output logic [7:0] d);
      addr = a;
      #0.2;
      d = rdata;
   endtask

   task automatic set_fields(input logic [7:0] base, input logic [47:0] t);
      for (int i = 0; i < 6; i++) wreg(base + 8'(4 * i), t[8*i +: 8]);
   endtask

   task automatic get_time(output logic [47:0] t);
      logic [7:0] b;
      for (int i = 0; i < 6; i++) begin
         rreg(8'(4 * i), b);
         t[8*i +: 8] = b;
      end
   endtask

   initial begin
      #(5.0 * 100000);
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [47:0] t;
      logic [7:0]  b;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      get_time(t);  chk("R1 reset time", 64'(t), 64'h00_01_01_00_00_00);
      rreg(8'h44, b); chk("R1 reset status", 64'(b), 64'h80);
      rreg(8'h40, b); chk("R1 reset control", 64'(b), 64'h00);
      rreg(8'h48, b); chk("R1 reset irq enable", 64'(b), 64'h00);
      chk("R1 reset irq outputs", 64'({irq_tick, irq_alarm}), 64'h0);

      // R4 stopped clock holds
      repeat (3 * TPS) @(negedge clk);
      get_time(t);  chk("R4 stopped time holds", 64'(t), 64'h00_01_01_00_00_00);
      rreg(8'h44, b); chk("R4 R6 stopped: not running, not busy", 64'(b[1:0]), 64'h0);

      // R8 power-up flag: write 0 ignored, write 1 clears
      wreg(8'h44, 8'h00);
      rreg(8'h44, b); chk("R8 write 0 keeps power-up flag", 64'(b[7]), 64'h1);
      wreg(8'h44, 8'h80);
      rreg(8'h44, b); chk("R8 write 1 clears power-up flag", 64'(b[7]), 64'h0);

      wreg(8'h40, 8'h01);
      rreg(8'h44, b); chk("R4 running bit", 64'(b[1]), 64'h1);

      // vector table: R2 R3 R6 R9
      foreach (VEC[k]) begin
         set_fields(8'h00, VEC[k].st);
         repeat (TPS - 2) @(negedge clk);
         rreg(8'h44, b); chk($sformatf("R6 busy low early v%0d", k), 64'(b[0]), 64'h0);
         @(negedge clk);
         rreg(8'h44, b); chk($sformatf("R6 busy before update v%0d", k), 64'(b[0]), 64'h1);
         get_time(t);  chk($sformatf("R5 time held before update v%0d", k), 64'(t), 64'(VEC[k].st));
         @(negedge clk);
         get_time(t);  chk($sformatf("R2 R3 time after update v%0d", k), 64'(t), 64'(VEC[k].ex));
         rreg(8'h44, b); chk($sformatf("R9 event bits v%0d", k), 64'(b & 8'h3D), 64'(VEC[k].ev));
         chk($sformatf("R10 tick irq masked v%0d", k), 64'(irq_tick), 64'h0);
         @(negedge clk);
         rreg(8'h44, b); chk($sformatf("R9 events cleared v%0d", k), 64'(b & 8'h3C), 64'h0);
      end

      // R5 second write restarts divider
      set_fields(8'h00, 48'h25_03_03_03_03_00);
      repeat (4) @(negedge clk);
      wreg(8'h00, 8'h10);
      repeat (TPS - 1) @(negedge clk);
      rreg(8'h00, b); chk("R5 restart delays update", 64'(b), 64'h10);
      @(negedge clk);
      rreg(8'h00, b); chk("R5 update after full second", 64'(b), 64'h11);

      // R7 alarm: one field differs -> no flag
      set_fields(8'h20, 48'h25_06_15_11_00_00);
      wreg(8'h48, 8'h08);
      set_fields(8'h00, 48'h24_06_15_10_59_59);
      repeat (TPS + 1) @(negedge clk);
      rreg(8'h44, b); chk("R7 year mismatch no alarm", 64'(b[6]), 64'h0);
      chk("R10 alarm irq low", 64'(irq_alarm), 64'h0);

      // R7 full match sets flag
      set_fields(8'h00, 48'h25_06_15_10_59_59);
      repeat (TPS + 1) @(negedge clk);
      rreg(8'h44, b); chk("R7 full match sets alarm", 64'(b[6]), 64'h1);
      chk("R10 alarm irq high", 64'(irq_alarm), 64'h1);
      wreg(8'h44, 8'h00);
      rreg(8'h44, b); chk("R8 write 0 keeps alarm flag", 64'(b[6]), 64'h1);
      wreg(8'h44, 8'h40);
      rreg(8'h44, b); chk("R8 write 1 clears alarm flag", 64'(b[6]), 64'h0);
      chk("R10 alarm irq drops", 64'(irq_alarm), 64'h0);

      // R8 set wins over clear in same cycle
      set_fields(8'h00, 48'h25_06_15_10_59_59);
      repeat (TPS) @(negedge clk);
      addr = 8'h44; wdata = 8'h40; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
      rreg(8'h44, b); chk("R8 match beats same-cycle clear", 64'(b[6]), 64'h1);
      wreg(8'h44, 8'h40);
      rreg(8'h44, b); chk("R8 later clear works", 64'(b[6]), 64'h0);

      // R10 periodic interrupt
      wreg(8'h48, 8'h0C);
      set_fields(8'h00, 48'h25_07_07_07_07_07);
      repeat (TPS - 1) @(negedge clk);
      chk("R10 tick irq idle", 64'(irq_tick), 64'h0);
      @(negedge clk);
      chk("R10 tick irq on second", 64'(irq_tick), 64'h1);
      @(negedge clk);
      chk("R10 tick irq one tick wide", 64'(irq_tick), 64'h0);

      // R4 stopping freezes time
      wreg(8'h40, 8'h00);
      get_time(t);
      repeat (3 * TPS) @(negedge clk);
      begin
         logic [47:0] t2;
         get_time(t2);
         chk("R4 stop freezes time", 64'(t2), 64'(t));
      end

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule